// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transceiver

This block is a byte-wide peripheral that converts parallel bytes into framed asynchronous serial characters and back. A processor reaches it through one port: a select line picks either the data path or the control path, and separate read and write strobes move bytes. Control writes are sequenced. The first control write after reset, or after a soft-reset command, is a format word. Every control write after that is a command word. A control read always returns the status byte.

The transmit path and the receive path each take their own bit clock, which runs at 1, 16 or 64 times the baud rate. Both clocks are brought into the system clock domain and edge-detected there. Serial output changes on falling edges of the transmit clock, and the line is sampled on rising edges of the receive clock. The format word sets character length (5 to 8 bits), parity and the number of stop bits. The transmitter has a holding register in front of its shift register. The receiver checks each start bit at half a bit time, reports parity, framing and overrun errors, and flags a line that is held low for too long. Two outputs and two inputs carry the modem handshake. All of these are active low.

Top module: `usrt_top`

## Requirements
- R1: After reset the status byte reads 0x05, `txd` is high, `dtr_n` and `rts_n` are high, and `rx_rdy`, `tx_rdy` and `brk_det` are low. The first control write after reset, or after a command with bit 6 set, is stored as the format word and does not act as a command. Status bits are: 0 holding register empty, 1 receive ready, 2 transmitter empty, 3 parity error, 4 overrun, 5 framing error, 6 break detect, 7 `dsr_n` asserted.
- R2: A transmitted character is framed as follows: idle high, one low start bit, then the data bits least significant first, then an optional parity bit, then high stop bits. Format word fields are [7:6] stop (10 or 11 = two stop bits, otherwise one), [5] even parity, [4] parity enable, [3:2] length minus 5, [1:0] rate. Odd parity makes the total count of ones odd.
- R3: Rate 01 gives one bit-clock period per bit, 10 gives 16 and 11 gives 64 (00 acts as 01). `txd` changes only after a falling edge of `txc`, except when the break command changes.
- R4: A data write fills the holding register and clears status bit 0. The byte moves to the shift register only when the shifter is idle. `tx_empty` is high only when both registers are empty.
- R5: A character starts only while command bit 0 (transmit enable) is set and `cts_n` is low. Otherwise the byte waits in the holding register. `tx_rdy` is the empty holding register qualified by both of these conditions.
- R6: On a low line the receiver waits half a bit time and samples again. If the line has returned high, the receiver discards the start and hunts again.
- R7: Receiving requires command bit 2. When a character is complete, `rx_rdy` rises and a data read returns the character right-aligned with its upper bits zero. The data read clears `rx_rdy`.
- R8: A wrong parity bit sets status bit 3. A low first stop bit sets status bit 5.
- R9: A character that completes while `rx_rdy` is still high replaces the buffered byte and sets status bit 4.
- R10: A command with bit 4 set clears status bits 3 to 5.
- R11: `brk_det` rises once `rxd` has stayed low for more than two full character times in receive-clock periods (rate × frame bits × 2). It falls when the line returns high.
- R12: Command bit 3 holds `txd` low while it is set.
- R13: Command bits 1 and 5 drive `dtr_n` and `rts_n` low when set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_sel | input | 1 | 1 = control/status path, 0 = data path |
| wr_en | input | 1 | Write strobe, one clock per byte |
| rd_en | input | 1 | Read strobe, one clock per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: status or received byte |
| txc | input | 1 | Transmit bit clock |
| rxc | input | 1 | Receive bit clock |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| tx_rdy | output | 1 | Holding register can take a byte |
| tx_empty | output | 1 | Nothing left to transmit |
| rx_rdy | output | 1 | Received byte waiting |
| brk_det | output | 1 | Receive line held low too long |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| cts_n | input | 1 | Clear to send, active low |

## Verification
The bench keeps the default two-stage synchronizer and a 12-bit break counter. It runs both bit clocks at one quarter of the system clock, which makes a bit 4, 64 or 256 system cycles long. With these settings the bench can loop the transmitter back into the receiver and sweep every length, parity and stop combination at rate 16, and check each frame bit at its centre. Rates 1 and 64 are checked on a single format each. Error frames, short glitches and a break long enough to cross the threshold are driven directly into the receiver.

// File: rtl/usrt_pkg.sv
package usrt_pkg;

    // Format word, bit 7 down to bit 0.
    typedef struct packed {
        logic [1:0] stop;
        logic       even;
        logic       pen;
        logic [1:0] len;
        logic [1:0] rate;
    } fmt_t;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_st_e;
    typedef enum logic [2:0] {RX_HUNT, RX_VALID, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI} rx_st_e;

    localparam int BYTE_W = 8;
    localparam int TICK_W = 7;

    function automatic logic [3:0] char_bits(fmt_t f);
        return 4'(f.len) + 4'd5;
    endfunction

    function automatic logic two_stops(fmt_t f);
        return f.stop[1];
    endfunction

    function automatic logic [TICK_W-1:0] bit_ticks(fmt_t f);
        case (f.rate)
            2'b10:   return TICK_W'(16);
            2'b11:   return TICK_W'(64);
            default: return TICK_W'(1);
        endcase
    endfunction

    function automatic logic [3:0] frame_bits(fmt_t f);
        return 4'd1 + char_bits(f) + 4'(f.pen) + (two_stops(f) ? 4'd2 : 4'd1);
    endfunction

endpackage

// File: rtl/usrt_sync.sv
module usrt_sync #(
    parameter int W = 1,
    parameter int N = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [N-1:0][W-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) stage <= {N{INIT}};
        else     stage <= {stage[N-2:0], d};
    end

    assign q = stage[N-1];
endmodule

// File: rtl/usrt_tx.sv
module usrt_tx
    import usrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  fmt_t              fmt,
    input  logic              ld,
    input  logic [BYTE_W-1:0] ld_data,
    input  logic              go,
    output logic              line,
    output logic              hold_empty,
    output logic              idle,
    output logic              xfer
);
    tx_st_e              st;
    logic                hold_full, par, stop2;
    logic [BYTE_W-1:0]   hold, sh;
    logic [TICK_W-1:0]   div;
    logic [3:0]          idx;
    logic [TICK_W-1:0]   last;

    assign last  = bit_ticks(fmt) - TICK_W'(1);
    assign xfer  = tick && (st == TX_IDLE) && hold_full && go;
    assign idle  = (st == TX_IDLE);
    assign hold_empty = !hold_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= TX_IDLE; hold_full <= 1'b0; hold <= '0; sh <= '0;
            div <= '0; idx <= '0; par <= 1'b0; stop2 <= 1'b0;
        end else begin
            if (ld) begin
                hold <= ld_data;
                hold_full <= 1'b1;
            end else if (xfer) begin
                hold_full <= 1'b0;
            end
            if (xfer) begin
                st <= TX_START; sh <= hold; div <= '0; idx <= '0;
                par <= 1'b0; stop2 <= 1'b0;
            end else if (tick && st != TX_IDLE) begin
                if (div == last) begin
                    div <= '0;
                    case (st)
                        TX_START: st <= TX_DATA;
                        TX_DATA: begin
                            par <= par ^ sh[0];
                            sh  <= sh >> 1;
                            idx <= idx + 4'd1;
                            if (idx == char_bits(fmt) - 4'd1)
                                st <= fmt.pen ? TX_PAR : TX_STOP;
                        end
                        TX_PAR: st <= TX_STOP;
                        default: begin
                            if (two_stops(fmt) && !stop2) stop2 <= 1'b1;
                            else                          st <= TX_IDLE;
                        end
                    endcase
                end else begin
                    div <= div + TICK_W'(1);
                end
            end
        end
    end

    always_comb begin
        case (st)
            TX_START: line = 1'b0;
            TX_DATA:  line = sh[0];
            TX_PAR:   line = fmt.even ? par : ~par;
            default:  line = 1'b1;
        endcase
    end
endmodule

// File: rtl/usrt_rx.sv
module usrt_rx
    import usrt_pkg::*;
#(
    parameter int BRK_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  fmt_t              fmt,
    input  logic              en,
    input  logic              rd_ack,
    input  logic              err_clr,
    output logic [BYTE_W-1:0] data,
    output logic              full,
    output logic              pe,
    output logic              oe,
    output logic              fe,
    output logic              load,
    output logic              brk
);
    rx_st_e            st;
    logic [TICK_W-1:0] cnt, tpb, half;
    logic [3:0]        idx;
    logic [BYTE_W-1:0] sh;
    logic              par, perr;
    logic              samp;
    logic [BRK_W-1:0]  low_cnt, thr;

    assign tpb  = bit_ticks(fmt);
    assign half = tpb >> 1;
    assign samp = tick && (cnt == tpb - TICK_W'(1));
    assign load = samp && (st == RX_STOP);
    assign thr  = BRK_W'(2) * BRK_W'(frame_bits(fmt)) * BRK_W'(tpb);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= RX_HUNT; cnt <= '0; idx <= '0; sh <= '0; par <= 1'b0; perr <= 1'b0;
        end else begin
            if (tick && st != RX_HUNT && st != RX_VALID && st != RX_WAITHI)
                cnt <= samp ? '0 : cnt + TICK_W'(1);
            case (st)
                RX_HUNT: if (tick && en && !rxd) begin
                    cnt <= '0; idx <= '0; par <= 1'b0; perr <= 1'b0;
                    st  <= (half == '0) ? RX_DATA : RX_VALID;
                end
                RX_VALID: if (tick) begin
                    if (cnt == half - TICK_W'(1)) begin
                        cnt <= '0;
                        st  <= rxd ? RX_HUNT : RX_DATA;
                    end else begin
                        cnt <= cnt + TICK_W'(1);
                    end
                end
                RX_DATA: if (samp) begin
                    sh  <= {rxd, sh[BYTE_W-1:1]};
                    par <= par ^ rxd;
                    idx <= idx + 4'd1;
                    if (idx == char_bits(fmt) - 4'd1)
                        st <= fmt.pen ? RX_PAR : RX_STOP;
                end
                RX_PAR: if (samp) begin
                    perr <= (rxd != (fmt.even ? par : ~par));
                    st   <= RX_STOP;
                end
                RX_STOP: if (samp) st <= rxd ? RX_HUNT : RX_WAITHI;
                default: if (tick && rxd) st <= RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0; full <= 1'b0; pe <= 1'b0; oe <= 1'b0; fe <= 1'b0;
        end else begin
            if (err_clr) begin
                pe <= 1'b0; oe <= 1'b0; fe <= 1'b0;
            end
            if (load) begin
                data <= sh >> (4'd8 - char_bits(fmt));
                full <= 1'b1;
                if (full && !rd_ack) oe <= 1'b1;
                if (perr)            pe <= 1'b1;
                if (!rxd)            fe <= 1'b1;
            end else if (rd_ack) begin
                full <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rxd) begin
            low_cnt <= '0; brk <= 1'b0;
        end else if (tick && !brk) begin
            if (low_cnt == thr) brk <= 1'b1;
            else                low_cnt <= low_cnt + BRK_W'(1);
        end
    end
endmodule

// File: rtl/usrt_top.sv
module usrt_top
    import usrt_pkg::*;
#(
    parameter int SYNC_N = 2,
    parameter int BRK_W  = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       txc,
    input  logic       rxc,
    output logic       txd,
    input  logic       rxd,
    output logic       tx_rdy,
    output logic       tx_empty,
    output logic       rx_rdy,
    output logic       brk_det,
    output logic       dtr_n,
    output logic       rts_n,
    input  logic       dsr_n,
    input  logic       cts_n
);
    logic txc_s, rxc_s, rxd_s, cts_s, dsr_s, txc_q, rxc_q;
    logic tx_tick, rx_tick;
    logic fmt_done, cmd_txen, cmd_dtr, cmd_rxen, cmd_sbrk, cmd_rts;
    fmt_t fmt;
    logic err_clr, tx_line, hold_empty, tx_idle, xfer;
    logic [7:0] rx_data, status;
    logic pe, oe, fe, rx_load;

    usrt_sync #(.W(5), .N(SYNC_N), .INIT(5'b00111)) u_sync (
        .clk(clk), .rst(rst),
        .d({txc, rxc, rxd, cts_n, dsr_n}),
        .q({txc_s, rxc_s, rxd_s, cts_s, dsr_s})
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            txc_q <= 1'b0; rxc_q <= 1'b0;
        end else begin
            txc_q <= txc_s; rxc_q <= rxc_s;
        end
    end
    assign tx_tick = txc_q & ~txc_s;
    assign rx_tick = ~rxc_q & rxc_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_done <= 1'b0; fmt <= '0;
            {cmd_txen, cmd_dtr, cmd_rxen, cmd_sbrk, cmd_rts} <= '0;
        end else if (wr_en && ctl_sel) begin
            if (!fmt_done) begin
                fmt <= fmt_t'(wdata);
                fmt_done <= 1'b1;
            end else if (wdata[6]) begin
                fmt_done <= 1'b0;
                {cmd_txen, cmd_dtr, cmd_rxen, cmd_sbrk, cmd_rts} <= '0;
            end else begin
                cmd_txen <= wdata[0];
                cmd_dtr  <= wdata[1];
                cmd_rxen <= wdata[2];
                cmd_sbrk <= wdata[3];
                cmd_rts  <= wdata[5];
            end
        end
    end
    assign err_clr = wr_en && ctl_sel && fmt_done && !wdata[6] && wdata[4];

    usrt_tx u_tx (
        .clk(clk), .rst(rst), .tick(tx_tick), .fmt(fmt),
        .ld(wr_en && !ctl_sel), .ld_data(wdata), .go(cmd_txen && !cts_s),
        .line(tx_line), .hold_empty(hold_empty), .idle(tx_idle), .xfer(xfer)
    );

    usrt_rx #(.BRK_W(BRK_W)) u_rx (
        .clk(clk), .rst(rst), .tick(rx_tick), .rxd(rxd_s), .fmt(fmt),
        .en(cmd_rxen), .rd_ack(rd_en && !ctl_sel), .err_clr(err_clr),
        .data(rx_data), .full(rx_rdy), .pe(pe), .oe(oe), .fe(fe),
        .load(rx_load), .brk(brk_det)
    );

    assign txd      = cmd_sbrk ? 1'b0 : tx_line;
    assign tx_empty = hold_empty && tx_idle;
    assign tx_rdy   = hold_empty && cmd_txen && !cts_s;
    assign dtr_n    = ~cmd_dtr;
    assign rts_n    = ~cmd_rts;
    assign status   = {~dsr_s, brk_det, fe, oe, pe, tx_empty, rx_rdy, hold_empty};
    assign rdata    = ctl_sel ? status : rx_data;
endmodule

// File: rtl/usrt_chk.sv
module usrt_chk (
    input logic       clk,
    input logic       rst,
    input logic       txd,
    input logic       tx_empty,
    input logic       cmd_sbrk,
    input logic       cmd_txen,
    input logic       tx_tick,
    input logic       xfer,
    input logic       cts_s,
    input logic       wr_en,
    input logic       rd_en,
    input logic       ctl_sel,
    input logic       hold_empty,
    input logic       rx_load,
    input logic       rx_rdy,
    input logic       err_clr,
    input logic [2:0] errs,
    input logic       brk_det,
    input logic       rxd_s
);
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !cmd_sbrk) |-> txd);

    assert_txd_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(txd) && $stable(cmd_sbrk)) |-> $past(tx_tick));

    assert_write_fills_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ctl_sel) |=> !hold_empty);

    assert_start_gated_R5: assert property (@(posedge clk) disable iff (rst)
        xfer |-> (cmd_txen && !cts_s));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !ctl_sel && !rx_load) |=> !rx_rdy);

    assert_err_reset_R10: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !rx_load) |=> (errs == 3'b000));

    assert_break_low_R11: assert property (@(posedge clk) disable iff (rst)
        brk_det |-> $past(!rxd_s));
endmodule

bind usrt_top usrt_chk u_chk (
    .clk(clk), .rst(rst), .txd(txd), .tx_empty(tx_empty), .cmd_sbrk(cmd_sbrk),
    .cmd_txen(cmd_txen), .tx_tick(tx_tick), .xfer(xfer), .cts_s(cts_s),
    .wr_en(wr_en), .rd_en(rd_en), .ctl_sel(ctl_sel), .hold_empty(hold_empty),
    .rx_load(rx_load), .rx_rdy(rx_rdy), .err_clr(err_clr), .errs({fe, oe, pe}),
    .brk_det(brk_det), .rxd_s(rxd_s)
);

// File: tb/tb_usrt_top.sv
`timescale 1ns/1ps
module tb_usrt_top;
    logic clk = 1'b0, rst = 1'b1;
    logic ctl_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic bclk = 1'b0, txd, rxd, rxd_drv = 1'b1, loop = 1'b0;
    logic tx_rdy, tx_empty, rx_rdy, brk_det, dtr_n, rts_n;
    logic dsr_n = 1'b1, cts_n = 1'b1;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;
    assign rxd = loop ? txd : rxd_drv;

    usrt_top dut (
        .clk(clk), .rst(rst), .ctl_sel(ctl_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .txc(bclk), .rxc(bclk), .txd(txd), .rxd(rxd),
        .tx_rdy(tx_rdy), .tx_empty(tx_empty), .rx_rdy(rx_rdy), .brk_det(brk_det),
        .dtr_n(dtr_n), .rts_n(rts_n), .dsr_n(dsr_n), .cts_n(cts_n)
    );

    initial forever begin
        repeat (2) @(negedge clk);
        bclk = ~bclk;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic [7:0] d);
        @(negedge clk); ctl_sel = c; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic c, output logic [7:0] v);
        @(negedge clk); ctl_sel = c; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic mk_frame(input logic [7:0] d, input int len, input bit pen, input bit even,
                            input bit two, output logic [15:0] b, output int nb);
        logic p;
        b = '0; nb = 0;
        b[nb++] = 1'b0;
        p = 1'b0;
        for (int i = 0; i < len; i++) begin
            b[nb++] = d[i];
            p ^= d[i];
        end
        if (pen) b[nb++] = even ? p : ~p;
        b[nb++] = 1'b1;
        if (two) b[nb++] = 1'b1;
    endtask

    task automatic cap_frame(input int nb, input int per, output logic [15:0] b);
        int t = 0;
        b = '1;
        while (txd !== 1'b0 && t < 40 * per) begin
            @(negedge clk); t++;
        end
        if (txd === 1'b0) begin
            repeat (per / 2) @(negedge clk);
            for (int i = 0; i < nb; i++) begin
                b[i] = txd;
                if (i != nb - 1) repeat (per) @(negedge clk);
            end
        end
    endtask

    task automatic drive_bits(input logic v, input int cycles);
        rxd_drv = v;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        drive_bits(1'b0, 64);
        for (int i = 0; i < 8; i++) drive_bits(d[i], 64);
        drive_bits((^d) ^ bad_par, 64);
        drive_bits(~bad_stop, 64);
        drive_bits(1'b1, 128);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, d, fw;
        logic [15:0] eb, gb, msk;
        int nb, per, k;
        bit flag;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        rd(1'b1, v);
        check("R1", "reset status", v, 8'h05);
        check("R1", "reset pins", {txd, dtr_n, rts_n, rx_rdy, tx_rdy, brk_det}, 6'b111000);
        // R1 first control write is the format word (0x4E has bit 1 set)
        wr(1'b1, 8'h4E);
        repeat (2) @(negedge clk);
        check("R1", "format word not a command", {dtr_n, rts_n}, 2'b11);
        // R13 modem outputs
        wr(1'b1, 8'h22);
        repeat (2) @(negedge clk);
        check("R13", "dtr/rts asserted", {dtr_n, rts_n}, 2'b00);
        wr(1'b1, 8'h00);
        repeat (2) @(negedge clk);
        check("R13", "dtr/rts released", {dtr_n, rts_n}, 2'b11);
        dsr_n = 1'b0;
        repeat (4) @(negedge clk);
        rd(1'b1, v);
        check("R13", "dsr status bit 7", v[7], 1);
        dsr_n = 1'b1;

        // R2 R3 R7 loopback sweep over format words
        loop = 1'b1; cts_n = 1'b0;
        k = 0;
        for (int cfg = 0; cfg < 26; cfg++) begin
            int len, pm, fac, rate;
            bit two;
            if (cfg < 24) begin
                len = 5 + cfg % 4; pm = (cfg / 4) % 3; two = (cfg / 12) != 0; rate = 2;
            end else if (cfg == 24) begin
                len = 8; pm = 2; two = 1'b1; rate = 3;
            end else begin
                len = 8; pm = 0; two = 1'b0; rate = 1;
            end
            fac = (rate == 3) ? 64 : (rate == 2) ? 16 : 1;
            per = 4 * fac;
            fw = {two ? 2'b11 : 2'b01, pm == 2, pm != 0, 2'(len - 5), 2'(rate)};
            wr(1'b1, 8'h40);
            wr(1'b1, fw);
            wr(1'b1, 8'h37);
            d = 8'(8'h5A + 37 * k) & 8'((1 << len) - 1);
            k++;
            mk_frame(d, len, pm != 0, pm == 2, two, eb, nb);
            msk = 16'((1 << nb) - 1);
            wr(1'b0, d);
            cap_frame(nb, per, gb);
            check(rate == 2 ? "R2" : "R3", $sformatf("frame fmt 0x%0h", fw), int'(gb & msk), int'(eb & msk));
            repeat (per + 8) @(negedge clk);
            rd(1'b1, v);
            check("R7", $sformatf("status after loopback fmt 0x%0h", fw), v, 8'h07);
            rd(1'b0, v);
            check("R7", $sformatf("data fmt 0x%0h", fw), v, d);
        end

        // R5 transmit gating, 8N1 rate 16
        loop = 1'b0; rxd_drv = 1'b1; per = 64;
        wr(1'b1, 8'h40); wr(1'b1, 8'h4E); wr(1'b1, 8'h01);
        cts_n = 1'b1;
        wr(1'b0, 8'hA7);
        flag = 1'b0;
        for (int i = 0; i < 3 * per; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) flag = 1'b1;
        end
        check("R5", "no start while cts_n high", flag, 0);
        check("R5", "tx_rdy/tx_empty while held", {tx_rdy, tx_empty}, 2'b00);
        cts_n = 1'b0;
        mk_frame(8'hA7, 8, 0, 0, 0, eb, nb);
        cap_frame(nb, per, gb);
        check("R5", "frame after cts_n low", int'(gb[9:0]), int'(eb[9:0]));
        repeat (per) @(negedge clk);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h5C);
        flag = 1'b0;
        for (int i = 0; i < 2 * per; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) flag = 1'b1;
        end
        check("R5", "no start without enable", flag, 0);
        wr(1'b1, 8'h01);
        mk_frame(8'h5C, 8, 0, 0, 0, eb, nb);
        cap_frame(nb, per, gb);
        check("R5", "frame after enable", int'(gb[9:0]), int'(eb[9:0]));
        repeat (per) @(negedge clk);

        // R4 double buffering
        wr(1'b0, 8'h31);
        repeat (8) @(negedge clk);
        check("R4", "holding freed, shifter busy", {tx_rdy, tx_empty}, 2'b10);
        wr(1'b0, 8'h62);
        check("R4", "second write fills holding", {tx_rdy, tx_empty}, 2'b00);
        mk_frame(8'h31, 8, 0, 0, 0, eb, nb);
        cap_frame(nb, per, gb);
        check("R4", "first frame", int'(gb[9:0]), int'(eb[9:0]));
        mk_frame(8'h62, 8, 0, 0, 0, eb, nb);
        cap_frame(nb, per, gb);
        check("R4", "second frame", int'(gb[9:0]), int'(eb[9:0]));
        repeat (per) @(negedge clk);
        check("R4", "tx_empty after drain", tx_empty, 1);

        // R12 send break
        wr(1'b1, 8'h09);
        repeat (3) @(negedge clk);
        check("R12", "txd held low", txd, 0);
        wr(1'b1, 8'h01);
        repeat (3) @(negedge clk);
        check("R12", "txd released", txd, 1);

        // Receiver errors: 8E1 rate 16, driven line
        wr(1'b1, 8'h40); wr(1'b1, 8'h7E); wr(1'b1, 8'h37);
        send_frame(8'h3C, 0, 0);
        rd(1'b1, v); check("R7", "good frame status", v, 8'h07);
        rd(1'b0, v); check("R7", "good frame data", v, 8'h3C);
        check("R7", "rx_rdy cleared by read", rx_rdy, 0);
        send_frame(8'h81, 1, 0);
        rd(1'b1, v); check("R8", "parity error status", v, 8'h0F);
        rd(1'b0, v); check("R8", "data with parity error", v, 8'h81);
        wr(1'b1, 8'h37);
        rd(1'b1, v); check("R10", "error reset clears", v, 8'h05);
        send_frame(8'h55, 0, 1);
        rd(1'b1, v); check("R8", "framing error status", v, 8'h27);
        rd(1'b0, v);
        wr(1'b1, 8'h37);
        send_frame(8'h11, 0, 0);
        send_frame(8'h22, 0, 0);
        rd(1'b1, v); check("R9", "overrun status", v, 8'h17);
        rd(1'b0, v); check("R9", "newest byte kept", v, 8'h22);
        wr(1'b1, 8'h37);
        rd(1'b1, v); check("R10", "overrun cleared", v, 8'h05);

        // R6 short low pulse is not a start bit
        drive_bits(1'b0, 16);
        drive_bits(1'b1, 3 * 64 * 11);
        check("R6", "glitch rejected", rx_rdy, 0);

        // R11 break detect: threshold 2*11*16 ticks = 1408 cycles
        drive_bits(1'b0, 1000);
        check("R11", "no break before two characters", brk_det, 0);
        drive_bits(1'b0, 600);
        check("R11", "break after two characters", brk_det, 1);
        rd(1'b1, v); check("R11", "break status bit 6", v[6], 1);
        drive_bits(1'b1, 8);
        check("R11", "break clears on high line", brk_det, 0);
        rd(1'b0, v);
        wr(1'b1, 8'h37);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule